// File: doc/BRIEF.md
# Two-Wire Bus Condition Control Register

This block is the control and status register that sits beside a two-wire serial port with open-drain data and clock lines. Software writes one-shot command bits that drive the data-output latch high (to put a stop condition on the bus) or low (to put a start condition on the bus). It can also request a software acknowledge, which pulls the data line low until the next falling edge of the clock line. Hardware watches the synchronised data and clock lines. It raises read-only flags when a start condition, a stop condition or an acknowledge is seen.

Each status flag has its own set of clear causes: a transfer-start strobe from the byte engine, an address-mismatch strobe from the address comparator, a stop condition, or dropping the interface enable. Shifting bytes, comparing addresses and generating the clock belong to neighbouring blocks, which feed this one through plain strobes.

Register fields, by bit position: 0 stop command, 1 start command, 2 stop seen, 3 start seen, 4 acknowledge pull request, 5 acknowledge-detect enable, 6 acknowledge seen, 7 busy enable.

Top module: `sbus_cond_ctl`

## Requirements
- R1: After reset, rd_data reads 0x00, sda_latch is 1, ack_pull is 0 and sda_drive_low is 0.
- R2: Bits 5 and 7 store the written value. Writes to bits 2, 3 and 6 have no effect on them.
- R3: Writing 1 to bit 0 while if_en is 1 makes bit 0 read 1 in the cycle after the write. One cycle later sda_latch is 1 and bit 0 reads 0. When bits 0 and 1 are written 1 together, sda_latch ends at 1.
- R4: Writing 1 to bit 1 alone while if_en is 1 makes bit 1 read 1 in the cycle after the write. One cycle later sda_latch is 0 and bit 1 reads 0.
- R5: While if_en is 0, bits 0, 1, 2, 3, 4 and 6 read 0 from the next cycle on. Writes to bits 0, 1 and 4 are ignored, and sda_latch keeps its value.
- R6: Writing 1 to bit 4 sets ack_pull from the next cycle. ack_pull stays set until a falling edge of scl_in has passed the synchroniser, at most 4 cycles after the edge. A xfer_start pulse also clears it in the following cycle.
- R7: A falling sda_in while scl_in is high sets bit 3 within 4 cycles. Bit 3 clears on a xfer_start pulse and on a detected stop condition. A stop wins over a start seen in the same cycle.
- R8: A rising sda_in while scl_in is high sets bit 2 within 4 cycles. Bit 2 clears on a xfer_start pulse or an addr_miss pulse.
- R9: With bit 5 set, a rising scl_in while sda_in is low sets bit 6. With bit 5 clear, bit 6 stays 0. Bit 6 clears on a xfer_start pulse.
- R10: sda_drive_low is 1 exactly when sda_latch is 0 or ack_pull is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_en | input | 1 | Serial interface enable |
| xfer_start | input | 1 | One-cycle strobe: a serial transfer begins |
| addr_miss | input | 1 | One-cycle strobe: received address did not match |
| wr_en | input | 1 | CPU register write strobe |
| wr_data | input | 8 | CPU write data |
| rd_data | output | 8 | Register read data |
| sda_in | input | 1 | Data line level, asynchronous |
| scl_in | input | 1 | Clock line level, asynchronous |
| sda_latch | output | 1 | Data-output latch |
| ack_pull | output | 1 | Software acknowledge pull-low active |
| sda_drive_low | output | 1 | Open-drain enable: drive the data line low |

## Verification
The bound checker checks the following relations on every cycle:
- the one-cycle life of each command bit and its effect on the latch;
- the clearing of all volatile bits while the interface is disabled;
- the clearing of flags by the transfer and address-miss strobes;
- that the acknowledge pull can only rise after a write asking for it.

Some behaviours can only be shown by the bench scenarios, which drive real bus waveforms through the synchroniser:
- detection of start and stop conditions, and a stop clearing the start flag;
- release of the acknowledge pull on a clock falling edge;
- acknowledge detection, with and without its enable;
- random register traffic, checked against a latch model.

// File: rtl/sbus_cond_pkg.sv
package sbus_cond_pkg;

   localparam int unsigned CTL_W = 8;

   localparam int unsigned FLD_CMD_STOP  = 0;
   localparam int unsigned FLD_CMD_START = 1;
   localparam int unsigned FLD_SEEN_STOP = 2;
   localparam int unsigned FLD_SEEN_STRT = 3;
   localparam int unsigned FLD_ACK_PULL  = 4;
   localparam int unsigned FLD_ACK_ENA   = 5;
   localparam int unsigned FLD_ACK_SEEN  = 6;
   localparam int unsigned FLD_BUSY_ENA  = 7;

   // packed order matches the field positions above (first member = bit 7)
   typedef struct packed {
      logic busy_ena;
      logic ack_seen;
      logic ack_ena;
      logic ack_pull;
      logic seen_strt;
      logic seen_stop;
      logic cmd_start;
      logic cmd_stop;
   } ctl_reg_t;

   typedef struct packed {
      logic strt_evt;
      logic stop_evt;
      logic scl_rise;
      logic scl_fall;
      logic sda_lvl;
   } line_evt_t;

endpackage

// File: rtl/sbus_cond_sync.sv
module sbus_cond_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          IDLE_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("sbus_cond_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{IDLE_LVL}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_async};
      end
   end

   assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/sbus_cond_line_mon.sv
module sbus_cond_line_mon
   import sbus_cond_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sda_in,
   input  logic      scl_in,
   output line_evt_t evt
);

   logic sda_s, scl_s;
   logic sda_d, scl_d;
   logic scl_held_hi;

   sbus_cond_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_sda_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (sda_in),
      .q_sync  (sda_s)
   );

   sbus_cond_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_scl_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (scl_in),
      .q_sync  (scl_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sda_d <= 1'b1;
         scl_d <= 1'b1;
      end else begin
         sda_d <= sda_s;
         scl_d <= scl_s;
      end
   end

   // clock must be high on both samples around the data edge
   assign scl_held_hi   = scl_s & scl_d;
   assign evt.strt_evt  = scl_held_hi &  sda_d & ~sda_s;
   assign evt.stop_evt  = scl_held_hi & ~sda_d &  sda_s;
   assign evt.scl_rise  = ~scl_d &  scl_s;
   assign evt.scl_fall  =  scl_d & ~scl_s;
   assign evt.sda_lvl   = sda_s;

endmodule

// File: rtl/sbus_cond_cmd.sv
module sbus_cond_cmd #(
   parameter bit LATCH_RST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic if_en,
   input  logic wr_stb,
   input  logic wr_stop,
   input  logic wr_start,
   output logic cmd_stop_q,
   output logic cmd_start_q,
   output logic latch_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_stop_q  <= 1'b0;
         cmd_start_q <= 1'b0;
         latch_q     <= LATCH_RST;
      end else begin
         // stop command outranks start command on the latch
         if (cmd_stop_q) begin
            latch_q <= 1'b1;
         end else if (cmd_start_q) begin
            latch_q <= 1'b0;
         end
         // command bits live for one cycle only
         cmd_stop_q  <= if_en & wr_stb & wr_stop;
         cmd_start_q <= if_en & wr_stb & wr_start;
      end
   end

endmodule

// File: rtl/sbus_cond_ack.sv
module sbus_cond_ack (
   input  logic clk,
   input  logic rst_n,
   input  logic if_en,
   input  logic xfer_start,
   input  logic wr_stb,
   input  logic wr_pull,
   input  logic ack_ena,
   input  logic scl_rise,
   input  logic scl_fall,
   input  logic sda_lvl,
   output logic pull_q,
   output logic seen_q
);

   logic kill;

   assign kill = ~if_en | xfer_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pull_q <= 1'b0;
      end else if (kill) begin
         pull_q <= 1'b0;
      end else if (wr_stb) begin
         pull_q <= wr_pull;
      end else if (scl_fall) begin
         pull_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
      end else if (kill) begin
         seen_q <= 1'b0;
      end else if (ack_ena & scl_rise & ~sda_lvl) begin
         seen_q <= 1'b1;
      end
   end

endmodule

// File: rtl/sbus_cond_ctl.sv
module sbus_cond_ctl
   import sbus_cond_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          LATCH_RST   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             if_en,
   input  logic             xfer_start,
   input  logic             addr_miss,
   input  logic             wr_en,
   input  logic [CTL_W-1:0] wr_data,
   output logic [CTL_W-1:0] rd_data,
   input  logic             sda_in,
   input  logic             scl_in,
   output logic             sda_latch,
   output logic             ack_pull,
   output logic             sda_drive_low
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("sbus_cond_ctl: SYNC_STAGES must be at least 2");
      end
      if (CTL_W != 8) begin : g_bad_width
         $error("sbus_cond_ctl: field map assumes an 8-bit register");
      end
   endgenerate

   line_evt_t evt;
   ctl_reg_t  view;
   logic      cmd_stop_q, cmd_start_q;
   logic      pull_q, ack_seen_q;
   logic      seen_stop_q, seen_strt_q;
   logic      ack_ena_q, busy_ena_q;
   logic      flag_kill;

   sbus_cond_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
      .clk    (clk),
      .rst_n  (rst_n),
      .sda_in (sda_in),
      .scl_in (scl_in),
      .evt    (evt)
   );

   sbus_cond_cmd #(.LATCH_RST(LATCH_RST)) u_cmd (
      .clk         (clk),
      .rst_n       (rst_n),
      .if_en       (if_en),
      .wr_stb      (wr_en),
      .wr_stop     (wr_data[FLD_CMD_STOP]),
      .wr_start    (wr_data[FLD_CMD_START]),
      .cmd_stop_q  (cmd_stop_q),
      .cmd_start_q (cmd_start_q),
      .latch_q     (sda_latch)
   );

   sbus_cond_ack u_ack (
      .clk        (clk),
      .rst_n      (rst_n),
      .if_en      (if_en),
      .xfer_start (xfer_start),
      .wr_stb     (wr_en),
      .wr_pull    (wr_data[FLD_ACK_PULL]),
      .ack_ena    (ack_ena_q),
      .scl_rise   (evt.scl_rise),
      .scl_fall   (evt.scl_fall),
      .sda_lvl    (evt.sda_lvl),
      .pull_q     (pull_q),
      .seen_q     (ack_seen_q)
   );

   assign flag_kill = ~if_en | xfer_start;

   // stop-seen flag: an address miss also clears it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_stop_q <= 1'b0;
      end else if (flag_kill | addr_miss) begin
         seen_stop_q <= 1'b0;
      end else if (evt.stop_evt) begin
         seen_stop_q <= 1'b1;
      end
   end

   // start-seen flag: a stop wins over a simultaneous start
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_strt_q <= 1'b0;
      end else if (flag_kill | evt.stop_evt) begin
         seen_strt_q <= 1'b0;
      end else if (evt.strt_evt) begin
         seen_strt_q <= 1'b1;
      end
   end

   // plain storage bits
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_ena_q  <= 1'b0;
         busy_ena_q <= 1'b0;
      end else if (wr_en) begin
         ack_ena_q  <= wr_data[FLD_ACK_ENA];
         busy_ena_q <= wr_data[FLD_BUSY_ENA];
      end
   end

   always_comb begin
      view.cmd_stop  = cmd_stop_q;
      view.cmd_start = cmd_start_q;
      view.seen_stop = seen_stop_q;
      view.seen_strt = seen_strt_q;
      view.ack_pull  = pull_q;
      view.ack_ena   = ack_ena_q;
      view.ack_seen  = ack_seen_q;
      view.busy_ena  = busy_ena_q;
   end

   assign rd_data       = view;
   assign ack_pull      = pull_q;
   assign sda_drive_low = ~sda_latch | pull_q;

endmodule

// File: rtl/sbus_cond_ctl_chk.sv
module sbus_cond_ctl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       if_en,
   input logic       xfer_start,
   input logic       addr_miss,
   input logic       wr_en,
   input logic [7:0] wr_data,
   input logic [7:0] rd_data,
   input logic       sda_latch,
   input logic       ack_pull
);

   AST_STOP_CMD_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[0] && !(wr_en && wr_data[0])) |=> (sda_latch && !rd_data[0])); // R3

   AST_START_CMD_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[1] && !rd_data[0] && !(wr_en && wr_data[1])) |=> (!sda_latch && !rd_data[1])); // R4

   AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !if_en |=> ((rd_data & 8'h5F) == 8'h00)); // R5

   AST_ACK_PULL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_pull) |-> $past(wr_en && wr_data[4] && if_en)); // R6

   AST_XFER_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |=> (!rd_data[3] && !rd_data[6] && !ack_pull)); // R7

   AST_MISS_CLEARS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_miss || xfer_start) |=> !rd_data[2]); // R8

   AST_ACK_SEEN_NEEDS_ENA: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_data[6]) |-> $past(rd_data[5])); // R9

endmodule

bind sbus_cond_ctl sbus_cond_ctl_chk chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .if_en      (if_en),
   .xfer_start (xfer_start),
   .addr_miss  (addr_miss),
   .wr_en      (wr_en),
   .wr_data    (wr_data),
   .rd_data    (rd_data),
   .sda_latch  (sda_latch),
   .ack_pull   (ack_pull)
);

// File: tb/sbus_cond_ctl_tb_top.sv
module sbus_cond_ctl_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       if_en = 1'b0;
   logic       xfer_start = 1'b0;
   logic       addr_miss = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       sda_in = 1'b1;
   logic       scl_in = 1'b1;
   logic       sda_latch, ack_pull, sda_drive_low;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   sbus_cond_ctl dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .if_en         (if_en),
      .xfer_start    (xfer_start),
      .addr_miss     (addr_miss),
      .wr_en         (wr_en),
      .wr_data       (wr_data),
      .rd_data       (rd_data),
      .sda_in        (sda_in),
      .scl_in        (scl_in),
      .sda_latch     (sda_latch),
      .ack_pull      (ack_pull),
      .sda_drive_low (sda_drive_low)
   );

   function automatic logic [7:0] exp_view_now(input logic [7:0] v);
      return v & 8'hB3;
   endfunction

   function automatic logic [7:0] exp_view_later(input logic [7:0] v);
      return v & 8'hB0;
   endfunction

   function automatic logic exp_latch(input logic [7:0] v, input logic old);
      if (v[0]) return 1'b1;
      if (v[1]) return 1'b0;
      return old;
   endfunction

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #2;
      end
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] v);
      wr_en = 1'b1;
      wr_data = v;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic lines(input logic sda, input logic scl);
      sda_in = sda;
      scl_in = scl;
      tick(4);
   endtask

   task automatic pulse_xfer();
      xfer_start = 1'b1;
      tick();
      xfer_start = 1'b0;
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      logic       lat;
      void'($urandom(32'd20240611));
      tick(3);
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk("R1 rd_data", rd_data, 8'h00);
      chk("R1 sda_latch", {7'd0, sda_latch}, 8'h01);
      chk("R1 ack_pull", {7'd0, ack_pull}, 8'h00);
      chk("R1 sda_drive_low", {7'd0, sda_drive_low}, 8'h00);

      if_en = 1'b1;
      tick();

      // random register traffic, bus idle
      lat = sda_latch;
      for (int k = 0; k < 40; k++) begin
         v = 8'($urandom);
         wr(v);
         chk("R2 R3 R4 readback after write", rd_data, exp_view_now(v));
         tick();
         lat = exp_latch(v, lat);
         chk("R2 R3 R4 readback settled", rd_data, exp_view_later(v));
         chk("R3 R4 latch", {7'd0, sda_latch}, {7'd0, lat});
         chk("R6 ack_pull", {7'd0, ack_pull}, {7'd0, v[4]});
         chk("R10 drive_low", {7'd0, sda_drive_low}, {7'd0, (~lat) | v[4]});
      end
      wr(8'h00);

      // stop and start commands together: stop wins
      wr(8'h02); tick();
      chk("R4 start drives latch low", {7'd0, sda_latch}, 8'h00);
      chk("R10 drive_low on latch low", {7'd0, sda_drive_low}, 8'h01);
      wr(8'h03); tick();
      chk("R3 stop wins over start", {7'd0, sda_latch}, 8'h01);

      // R5 disable
      if_en = 1'b0;
      wr(8'h13);
      chk("R5 writes ignored when disabled", rd_data, 8'h00);
      tick();
      chk("R5 latch kept", {7'd0, sda_latch}, 8'h01);
      wr(8'h02); tick();
      chk("R5 start ignored when disabled", {7'd0, sda_latch}, 8'h01);
      if_en = 1'b1;
      tick();

      // R7 start detection, then stop clears it and sets R8
      lines(1'b0, 1'b1);
      chk("R7 start seen", rd_data & 8'h0C, 8'h08);
      pulse_xfer();
      chk("R7 xfer clears start", rd_data & 8'h0C, 8'h00);
      lines(1'b0, 1'b0);
      lines(1'b0, 1'b1);
      chk("R7 no start without data edge", rd_data & 8'h0C, 8'h00);
      lines(1'b1, 1'b1);
      chk("R8 stop seen", rd_data & 8'h0C, 8'h04);
      addr_miss = 1'b1; tick(); addr_miss = 1'b0;
      chk("R8 addr_miss clears stop", rd_data & 8'h0C, 8'h00);
      lines(1'b0, 1'b1);
      chk("R7 start seen again", rd_data & 8'h0C, 8'h08);
      lines(1'b1, 1'b1);
      chk("R7 stop clears start", rd_data & 8'h0C, 8'h04);
      pulse_xfer();
      chk("R8 xfer clears stop", rd_data & 8'h0C, 8'h00);
      lines(1'b0, 1'b1);
      if_en = 1'b0;
      tick();
      chk("R5 disable clears start flag", rd_data & 8'h0C, 8'h00);
      if_en = 1'b1;
      tick();
      lines(1'b1, 1'b1);

      // R6 software acknowledge
      wr(8'h10);
      chk("R6 ack_pull after write", {7'd0, ack_pull}, 8'h01);
      chk("R10 drive_low with ack", {7'd0, sda_drive_low}, 8'h01);
      scl_in = 1'b0;
      tick();
      chk("R6 ack held before fall seen", {7'd0, ack_pull}, 8'h01);
      tick(3);
      chk("R6 ack released after scl fall", {7'd0, ack_pull}, 8'h00);
      chk("R10 drive released", {7'd0, sda_drive_low}, 8'h00);
      wr(8'h10);
      pulse_xfer();
      chk("R6 xfer clears ack", {7'd0, ack_pull}, 8'h00);

      // R9 acknowledge detection
      wr(8'h20);
      lines(1'b0, 1'b0);
      lines(1'b0, 1'b1);
      chk("R9 ack seen", rd_data & 8'h60, 8'h60);
      pulse_xfer();
      chk("R9 xfer clears ack seen", rd_data & 8'h60, 8'h20);
      wr(8'h00);
      lines(1'b0, 1'b0);
      lines(1'b0, 1'b1);
      chk("R9 no ack seen when disabled", rd_data & 8'h60, 8'h00);
      lines(1'b0, 1'b0);
      lines(1'b1, 1'b0);
      lines(1'b1, 1'b1);

      // R2 read-only bits ignore writes
      pulse_xfer();
      wr(8'h4C);
      chk("R2 read-only bits ignore write", rd_data, 8'h00);
      tick();
      chk("R2 read-only bits stay clear", rd_data, 8'h00);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule